// File: doc/BRIEF.md
# Dual DAC serial command receiver

This block is the digital front end of a two-channel, 8-bit digital-to-analog converter. A host writes 16-bit command words over a 3-wire serial link made of an active-low select, a serial clock and a data line. The block samples those pins with its own, faster system clock, shifts the data into a word register and acts on the word only when the select line returns high.

Each command word carries a control byte followed by a data byte. The control byte is not decoded as a whole: one bit per channel loads the data byte into that channel's code register, and one bit per channel places that channel in shutdown. A channel in shutdown presents a zero code while keeping its stored value, so it comes back at the old level when it is released. The remaining control bits carry no meaning. The two effective codes and the two power-down flags drive the analog section directly.

Top module: `dual_dac_cmd_rx`

## Requirements
- R1: While rst_ni is low, both stored codes are cleared and both channels are active, so both code outputs read 0 and both power-down outputs read 0.
- R2: Serial clock rising edges that occur while cs_ni is high neither shift data nor execute a command.
- R3: Bits enter the 16-bit word first-in at bit 15; on the wire the order is bit 15 down to bit 0, bits 7..0 are the data byte (most significant first) and bit 8 loads channel A, bit 9 loads channel B, bit 11 shuts down channel A, bit 12 shuts down channel B.
- R4: A command executes only on a rising edge of cs_ni; while cs_ni stays low, no code or power-down output changes, however many bits arrive.
- R5: A word may be sent in several bursts with the serial clock idle in between, as long as cs_ni stays low throughout.
- R6: On execution, a set bit 8 copies the data byte into channel A's code, a set bit 9 into channel B's; with both set both receive it, with neither set both codes keep their values.
- R7: Every executed command rewrites both shutdown flags from bits 11 and 12; a channel in shutdown drives code 0 and pd high, and its stored code survives so a later release restores it.
- R8: Bits 15, 14, 13 and 10 have no effect on any output.
- R9: When more than 16 serial clock edges occur in one frame, the last 16 bits received form the command.
- R10: When fewer than 16 edges occur, the command executes on the register as it stands: earlier contents shifted up by the number of new bits.
- R11: The outputs reflect an executed command no later than 4 system clock cycles after cs_ni rises, given a system clock at least 4 times the serial clock rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to sample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, data taken on its rising edge |
| cs_ni | input | 1 | Active-low frame select; its rising edge executes the word |
| sdi_i | input | 1 | Serial data in |
| code_a_o | output | 8 | Effective code of channel A (0 while shut down) |
| code_b_o | output | 8 | Effective code of channel B (0 while shut down) |
| pd_a_o | output | 1 | Channel A power-down flag |
| pd_b_o | output | 1 | Channel B power-down flag |

## Verification
The bench targets a frame held open after 16 bits, where a design that executes on the bit count rather than on the select edge would change its outputs early. It sends over-long frames led by all-ones bits, which a design keeping the first 16 bits would read as a double shutdown, and a short frame preceded by clocks with select high, which a design that shifts outside the frame would turn into a different control byte. It also releases a channel from shutdown without a load, catching a design that clears the stored code instead of masking it, and sets every meaningless control bit to expose any accidental decode.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned NUM_CH = 2;

  // control bit positions inside the shifted word; channel index 0 = A, 1 = B
  function automatic int unsigned load_pos(int unsigned code_w, int unsigned ch);
    return code_w + ch;
  endfunction

  function automatic int unsigned shdn_pos(int unsigned code_w, int unsigned ch);
    return code_w + 3 + ch;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              cs_ns_i,
  input  logic              sdi_s_i,
  output logic [WORD_W-1:0] word_o,
  output logic              exec_o
);
  logic              sclk_q, cs_q;
  logic [WORD_W-1:0] sr_q;
  logic              sclk_rise;

  assign sclk_rise = sclk_s_i & ~sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      sr_q   <= '0;
    end else begin
      sclk_q <= sclk_s_i;
      cs_q   <= cs_ns_i;
      if (sclk_rise && !cs_ns_i) sr_q <= {sr_q[WORD_W-2:0], sdi_s_i};
    end
  end

  assign word_o = sr_q;
  assign exec_o = cs_ns_i & ~cs_q;

  // R2
  hold_when_deselected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ns_i |=> $stable(sr_q));

  // R4
  single_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> !exec_o);
endmodule

// File: rtl/chan_reg.sv
module chan_reg #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic              load_i,
  input  logic              shdn_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o,
  output logic              pd_o
);
  logic [CODE_W-1:0] code_q;
  logic              pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      pd_q   <= 1'b0;
    end else if (exec_i) begin
      pd_q <= shdn_i;
      if (load_i) code_q <= data_i;
    end
  end

  // stored value is masked, never cleared, by shutdown
  assign code_o = pd_q ? '0 : code_q;
  assign pd_o   = pd_q;

  // R6
  load_takes_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && load_i) |=> (code_q == $past(data_i)));

  // R6
  no_load_keeps_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exec_i && load_i) |=> $stable(code_q));

  // R7
  shdn_rewritten_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> (pd_q == $past(shdn_i)));

  // R4
  shdn_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(pd_q));
endmodule

// File: rtl/dual_dac_cmd_rx.sv
module dual_dac_cmd_rx
  import dac_rx_pkg::*;
#(
  parameter int unsigned DATA_W = dac_rx_pkg::CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] code_a_o,
  output logic [DATA_W-1:0] code_b_o,
  output logic              pd_a_o,
  output logic              pd_b_o
);
  localparam int unsigned WORD_W = 2 * DATA_W;

  logic              sclk_s, cs_ns, sdi_s;
  logic [WORD_W-1:0] word;
  logic              exec;
  logic [DATA_W-1:0] code_arr [NUM_CH];
  logic [NUM_CH-1:0] pd_arr;
  logic              unused_bits;

  // bit order {sclk, cs, sdi}; cs idles high
  pin_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b010)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, cs_ni, sdi_i}),
    .q_o    ({sclk_s, cs_ns, sdi_s})
  );

  serial_shifter #(.WORD_W(WORD_W)) i_shifter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_s_i (sclk_s),
    .cs_ns_i  (cs_ns),
    .sdi_s_i  (sdi_s),
    .word_o   (word),
    .exec_o   (exec)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_reg #(.CODE_W(DATA_W)) i_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .exec_i (exec),
      .load_i (word[load_pos(DATA_W, c)]),
      .shdn_i (word[shdn_pos(DATA_W, c)]),
      .data_i (word[DATA_W-1:0]),
      .code_o (code_arr[c]),
      .pd_o   (pd_arr[c])
    );
  end

  // uncommitted control bits carry no function
  assign unused_bits = ^{word[WORD_W-1:WORD_W-3], word[DATA_W+2]};

  assign code_a_o = code_arr[0];
  assign code_b_o = code_arr[1];
  assign pd_a_o   = pd_arr[0];
  assign pd_b_o   = pd_arr[1];
endmodule

// File: tb/test_dual_dac_cmd_rx.sv
module test_dual_dac_cmd_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic [7:0] code_a, code_b;
  logic       pd_a, pd_b;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  dual_dac_cmd_rx i_dual_dac_cmd_rx (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi),
    .code_a_o(code_a), .code_b_o(code_b), .pd_a_o(pd_a), .pd_b_o(pd_b)
  );

  // {word, exp code A, exp code B, exp pd A, exp pd B}
  localparam logic [33:0] VEC [9] = '{
    {16'h0380, 8'h80, 8'h80, 2'b00},
    {16'h015A, 8'h5A, 8'h80, 2'b00},
    {16'h02C3, 8'h5A, 8'hC3, 2'b00},
    {16'h00FF, 8'h5A, 8'hC3, 2'b00},
    {16'h0811, 8'h00, 8'hC3, 2'b10},
    {16'h1121, 8'h21, 8'h00, 2'b01},
    {16'hE477, 8'h21, 8'hC3, 2'b00},
    {16'h1B3C, 8'h00, 8'h00, 2'b11},
    {16'h0000, 8'h3C, 8'h3C, 2'b00}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [17:0] exp);
    logic [17:0] act;
    act = {code_a, code_b, pd_a, pd_b};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual a=%h b=%h pd=%b expected a=%h b=%h pd=%b",
               req, act[17:10], act[9:2], act[1:0], exp[17:10], exp[9:2], exp[1:0]);
    end
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
  endtask

  task automatic open_frame();
    cs_n = 1'b0;
    wait_clk(4);
  endtask

  task automatic close_frame();
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(4);
  endtask

  task automatic send_word(input logic [15:0] w);
    open_frame();
    shift_bits({16'h0, w}, 16);
    close_frame();
  endtask

  initial begin
    wait_clk(5);
    // R1
    check("R1 reset", {8'h00, 8'h00, 2'b00});
    rst_n = 1'b1;
    wait_clk(4);

    for (int i = 0; i < 9; i++) begin
      send_word(VEC[i][33:18]);
      check($sformatf("R3 R6 R7 R8 R11 vector %0d", i), VEC[i][17:0]);
      wait_clk(4);
    end

    // R4: full word shifted, select still low
    open_frame();
    shift_bits({16'h0, 16'h0399}, 16);
    wait_clk(12);
    check("R4 held before select rise", {8'h3C, 8'h3C, 2'b00});
    close_frame();
    check("R4 executed at select rise", {8'h99, 8'h99, 2'b00});
    wait_clk(4);

    // R5: two bursts with idle clock between
    open_frame();
    shift_bits({24'h0, 8'h01}, 8);
    wait_clk(20);
    shift_bits({24'h0, 8'h42}, 8);
    close_frame();
    check("R5 split word", {8'h42, 8'h99, 2'b00});
    wait_clk(4);

    // R9: eight leading ones then a full word
    open_frame();
    shift_bits({8'h0, 8'hFF, 16'h0277}, 24);
    close_frame();
    check("R9 last sixteen bits kept", {8'h42, 8'h77, 2'b00});
    wait_clk(4);

    // R2: clocks and data while deselected
    sdi = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(6);
    check("R2 deselected clocks ignored", {8'h42, 8'h77, 2'b00});

    // R10: short frame; word becomes {77, 1F} -> load both, B shut
    open_frame();
    shift_bits({24'h0, 8'h1F}, 8);
    close_frame();
    check("R10 short frame shifted contents", {8'h1F, 8'h00, 2'b01});
    wait_clk(4);

    // R7: release without load restores stored code
    send_word(16'h0000);
    check("R7 release restores stored code", {8'h1F, 8'h1F, 2'b00});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule